// File: doc/BRIEF.md
# Link Interrupt Carrier and Receive Fill Filter

This block moves a single interrupt level from one end of a serial character link to the other, and filters what the receiving end keeps. Characters cross the link as an 8-bit code plus a special (K) flag; line coding and serialization are handled elsewhere. On the sending side, every change of the local interrupt level arms a one-character request. The request is placed in the next character slot ahead of any queued data, and it never enters the data queue. A slot with neither a request nor data carries an idle fill character.

On the receiving side, the two interrupt command characters drive a registered interrupt output. A two-bit policy decides which incoming characters reach a small receive FIFO. Policy 0 keeps everything. Policy 1 removes the commands and reduces every run of fill characters to a single stored fill. Policies 2 and 3 remove the commands and all fills. The FIFO reports data as available only when it holds something other than fill. Code values: interrupt-set is 0x1C with K=1, interrupt-clear is 0x7C with K=1, fill is 0xBC with K=1. Any other character, including those byte values with K=0, is ordinary traffic.

Top module: `link_irq_fill_top`

## Requirements
- R1: A rising edge on tx_irq_lvl arms a request. The next cycle with tx_slot high carries it, and one cycle later tx_chr_code is 0x1C with tx_chr_k = 1.
- R2: A falling edge on tx_irq_lvl arms a request that is sent the same way as 0x7C with tx_chr_k = 1.
- R3: If the level changes more than once before a slot carries the request, exactly one command is sent, and it encodes the level present after the last change.
- R4: A pending request takes the slot, so tx_dat_ready is low in that cycle. tx_dat_ready equals tx_slot and tx_dat_valid with no request pending. Accepted data leaves unchanged, with its K flag, one cycle after acceptance.
- R5: tx_chr_valid is high exactly one cycle after each cycle with tx_slot high. A slot with no request and no valid data carries fill (0xBC, K = 1).
- R6: A received 0x1C with K = 1 sets rx_irq on the following cycle, and 0x7C with K = 1 clears it, under every policy. The same bytes with K = 0 leave rx_irq unchanged.
- R7: With rx_policy = 0, every received character is stored in arrival order.
- R8: With rx_policy = 1, commands are not stored, and a fill is stored only when the most recently stored character was not a fill. All other characters are stored.
- R9: With rx_policy = 2 or 3, neither commands nor fills are stored.
- R10: rx_avail is high exactly when the FIFO holds at least one entry that is not a fill.
- R11: rx_rd on a non-empty FIFO pops the oldest entry, and rx_rd_vld goes high with its code and K flag on the next cycle. rx_rd on an empty FIFO is ignored. Holding RX_DEPTH entries raises rx_full, and further stores are dropped.
- R12: Synchronous active-high rst leaves no request pending, the FIFO empty and the last-stored-was-fill flag clear. It drives tx_chr_valid, rx_irq, rx_avail, rx_full and rx_rd_vld low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_irq_lvl | input | 1 | Local interrupt level to carry |
| tx_slot | input | 1 | One outgoing character slot this cycle |
| tx_dat_valid | input | 1 | Queued data character offered |
| tx_dat_code | input | 8 | Offered data code |
| tx_dat_k | input | 1 | Offered data special flag |
| tx_dat_ready | output | 1 | Offered character taken this cycle |
| tx_chr_valid | output | 1 | Outgoing character valid |
| tx_chr_code | output | 8 | Outgoing code |
| tx_chr_k | output | 1 | Outgoing special flag |
| rx_chr_valid | input | 1 | Received character valid |
| rx_chr_code | input | 8 | Received code |
| rx_chr_k | input | 1 | Received special flag |
| rx_policy | input | 2 | Discard policy |
| rx_irq | output | 1 | Recovered interrupt level |
| rx_rd | input | 1 | Pop request for the receive FIFO |
| rx_rd_vld | output | 1 | Popped entry valid |
| rx_rd_code | output | 8 | Popped code |
| rx_rd_k | output | 1 | Popped special flag |
| rx_avail | output | 1 | FIFO holds a non-fill entry |
| rx_full | output | 1 | FIFO full |

## Verification
On the send side, an interrupt edge and a data slot meet in the same cycle: the edge arms a request while arbitration for that slot is already deciding on the previous request state. Random stimulus toggles the level on slot cycles, with data present and absent. A cycle model built from R1 to R5 predicts tx_dat_ready and the character one cycle later, so the outcome of each collision is judged. On the receive side, a command and a fill can both arrive while a fill run is open. Random streams under all four policies mix the two, and each stream's FIFO contents are compared entry by entry against the policy rules.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_IRQ_SET = 8'h1C;
  localparam logic [CODE_W-1:0] CODE_IRQ_CLR = 8'h7C;
  localparam logic [CODE_W-1:0] CODE_FILL    = 8'hBC;

  typedef enum logic [1:0] {
    POL_KEEP_ALL = 2'd0,
    POL_ONE_FILL = 2'd1,
    POL_STRIP_A  = 2'd2,
    POL_STRIP_B  = 2'd3
  } lif_policy_e;
endpackage

// File: rtl/lif_tx_inject.sv
module lif_tx_inject
  import lif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_lvl,
  input  logic              slot,
  input  logic              dat_valid,
  input  logic [CODE_W-1:0] dat_code,
  input  logic              dat_k,
  output logic              dat_ready,
  output logic              chr_valid,
  output logic [CODE_W-1:0] chr_code,
  output logic              chr_k
);
  logic irq_q;
  logic pend;
  logic pend_lvl;
  logic lvl_edge;

  assign lvl_edge  = irq_lvl ^ irq_q;
  assign dat_ready = slot & ~pend & dat_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= 1'b0;
      pend      <= 1'b0;
      pend_lvl  <= 1'b0;
      chr_valid <= 1'b0;
      chr_code  <= '0;
      chr_k     <= 1'b0;
    end else begin
      irq_q <= irq_lvl;
      if (lvl_edge) begin
        pend     <= 1'b1;
        pend_lvl <= irq_lvl;
      end else if (slot) begin
        pend <= 1'b0;
      end
      chr_valid <= slot;
      if (slot) begin
        if (pend) begin
          chr_code <= pend_lvl ? CODE_IRQ_SET : CODE_IRQ_CLR;
          chr_k    <= 1'b1;
        end else if (dat_valid) begin
          chr_code <= dat_code;
          chr_k    <= dat_k;
        end else begin
          chr_code <= CODE_FILL;
          chr_k    <= 1'b1;
        end
      end
    end
  end

  AST_CMD_TAKES_SLOT: assert property (@(posedge clk) disable iff (rst)
    (slot && pend) |=> (chr_valid && chr_k &&
      chr_code == ($past(pend_lvl) ? CODE_IRQ_SET : CODE_IRQ_CLR))); // R4
  AST_EDGE_ARMS: assert property (@(posedge clk) disable iff (rst)
    lvl_edge |=> (pend && pend_lvl == $past(irq_lvl))); // R3
  AST_SLOT_VALID: assert property (@(posedge clk) disable iff (rst)
    slot |=> chr_valid); // R5
  AST_NO_SLOT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !slot |=> !chr_valid); // R5
endmodule

// File: rtl/lif_rx_filter.sv
module lif_rx_filter
  import lif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_k,
  input  logic [1:0]        policy,
  output logic              irq,
  output logic              wr_en,
  output logic [CODE_W-1:0] wr_code,
  output logic              wr_k,
  output logic              wr_fill
);
  logic is_set, is_clr, is_cmd, is_fill;
  logic last_fill;
  logic keep;

  assign is_set  = in_valid & in_k & (in_code == CODE_IRQ_SET);
  assign is_clr  = in_valid & in_k & (in_code == CODE_IRQ_CLR);
  assign is_cmd  = is_set | is_clr;
  assign is_fill = in_valid & in_k & (in_code == CODE_FILL);

  always_comb begin
    case (lif_policy_e'(policy))
      POL_KEEP_ALL: keep = in_valid;
      POL_ONE_FILL: keep = in_valid & ~is_cmd & ~(is_fill & last_fill);
      default:      keep = in_valid & ~is_cmd & ~is_fill;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      wr_en     <= 1'b0;
      wr_code   <= '0;
      wr_k      <= 1'b0;
      wr_fill   <= 1'b0;
      last_fill <= 1'b0;
    end else begin
      if (is_set)      irq <= 1'b1;
      else if (is_clr) irq <= 1'b0;
      wr_en   <= keep;
      wr_code <= in_code;
      wr_k    <= in_k;
      wr_fill <= is_fill;
      if (keep) last_fill <= is_fill;
    end
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    is_set |=> irq); // R6
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
    is_clr |=> !irq); // R6
  AST_KEEP_ALL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && policy == 2'd0) |=> wr_en); // R7
  AST_NO_CMD_STORED: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && policy != 2'd0) |=> !wr_en); // R8
  AST_STRIP_FILL: assert property (@(posedge clk) disable iff (rst)
    (is_fill && policy[1]) |=> !wr_en); // R9
endmodule

// File: rtl/lif_rx_fifo.sv
module lif_rx_fifo
  import lif_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_k,
  input  logic              wr_fill,
  input  logic              rd_en,
  output logic              rd_vld,
  output logic [CODE_W-1:0] rd_code,
  output logic              rd_k,
  output logic              avail,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DW = CODE_W + 1;
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    rd_q;
  logic [DEPTH-1:0] fill_flag;
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt, cnt_n;
  logic [AW:0]      nf, nf_n;
  logic             do_wr, do_rd, wr_nf, rd_nf;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign do_rd = rd_en & (cnt != '0);
  assign do_wr = wr_en & ((cnt != FULL_CNT) | do_rd);
  assign wr_nf = do_wr & ~wr_fill;
  assign rd_nf = do_rd & ~fill_flag[rp];

  always_comb begin
    case ({do_wr, do_rd})
      2'b10:   cnt_n = cnt + 1'b1;
      2'b01:   cnt_n = cnt - 1'b1;
      default: cnt_n = cnt;
    endcase
    case ({wr_nf, rd_nf})
      2'b10:   nf_n = nf + 1'b1;
      2'b01:   nf_n = nf - 1'b1;
      default: nf_n = nf;
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= {wr_k, wr_code};
    if (do_rd) rd_q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      nf        <= '0;
      fill_flag <= '0;
      rd_vld    <= 1'b0;
      avail     <= 1'b0;
      full      <= 1'b0;
    end else begin
      if (do_wr) begin
        wp            <= ptr_inc(wp);
        fill_flag[wp] <= wr_fill;
      end
      if (do_rd) rp <= ptr_inc(rp);
      cnt    <= cnt_n;
      nf     <= nf_n;
      rd_vld <= do_rd;
      avail  <= (nf_n != '0);
      full   <= (cnt_n == FULL_CNT);
    end
  end

  assign rd_k    = rd_q[DW-1];
  assign rd_code = rd_q[CODE_W-1:0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT); // R11
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> ($past(cnt) != '0)); // R11
  AST_AVAIL_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    avail |-> (cnt != '0)); // R10
  AST_NONFILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    nf <= cnt); // R10
endmodule

// File: rtl/link_irq_fill_top.sv
module link_irq_fill_top
  import lif_pkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_irq_lvl,
  input  logic       tx_slot,
  input  logic       tx_dat_valid,
  input  logic [7:0] tx_dat_code,
  input  logic       tx_dat_k,
  output logic       tx_dat_ready,
  output logic       tx_chr_valid,
  output logic [7:0] tx_chr_code,
  output logic       tx_chr_k,
  input  logic       rx_chr_valid,
  input  logic [7:0] rx_chr_code,
  input  logic       rx_chr_k,
  input  logic [1:0] rx_policy,
  output logic       rx_irq,
  input  logic       rx_rd,
  output logic       rx_rd_vld,
  output logic [7:0] rx_rd_code,
  output logic       rx_rd_k,
  output logic       rx_avail,
  output logic       rx_full
);
  logic              st_en;
  logic [CODE_W-1:0] st_code;
  logic              st_k;
  logic              st_fill;

  lif_tx_inject u_tx (
    .clk       (clk),
    .rst       (rst),
    .irq_lvl   (tx_irq_lvl),
    .slot      (tx_slot),
    .dat_valid (tx_dat_valid),
    .dat_code  (tx_dat_code),
    .dat_k     (tx_dat_k),
    .dat_ready (tx_dat_ready),
    .chr_valid (tx_chr_valid),
    .chr_code  (tx_chr_code),
    .chr_k     (tx_chr_k)
  );

  lif_rx_filter u_filt (
    .clk      (clk),
    .rst      (rst),
    .in_valid (rx_chr_valid),
    .in_code  (rx_chr_code),
    .in_k     (rx_chr_k),
    .policy   (rx_policy),
    .irq      (rx_irq),
    .wr_en    (st_en),
    .wr_code  (st_code),
    .wr_k     (st_k),
    .wr_fill  (st_fill)
  );

  lif_rx_fifo #(.DEPTH(RX_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (st_en),
    .wr_code (st_code),
    .wr_k    (st_k),
    .wr_fill (st_fill),
    .rd_en   (rx_rd),
    .rd_vld  (rx_rd_vld),
    .rd_code (rx_rd_code),
    .rd_k    (rx_rd_k),
    .avail   (rx_avail),
    .full    (rx_full)
  );
endmodule

// File: tb/link_irq_fill_top_tb_top.sv
module link_irq_fill_top_tb_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_irq_lvl = 1'b0, tx_slot = 1'b0, tx_dat_valid = 1'b0, tx_dat_k = 1'b0;
  logic [7:0] tx_dat_code = '0;
  logic       tx_dat_ready, tx_chr_valid, tx_chr_k;
  logic [7:0] tx_chr_code;
  logic       rx_chr_valid = 1'b0, rx_chr_k = 1'b0, rx_rd = 1'b0;
  logic [7:0] rx_chr_code = '0;
  logic [1:0] rx_policy = '0;
  logic       rx_irq, rx_rd_vld, rx_rd_k, rx_avail, rx_full;
  logic [7:0] rx_rd_code;

  always #4 clk = ~clk;

  link_irq_fill_top #(.RX_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .tx_irq_lvl(tx_irq_lvl), .tx_slot(tx_slot), .tx_dat_valid(tx_dat_valid),
    .tx_dat_code(tx_dat_code), .tx_dat_k(tx_dat_k), .tx_dat_ready(tx_dat_ready),
    .tx_chr_valid(tx_chr_valid), .tx_chr_code(tx_chr_code), .tx_chr_k(tx_chr_k),
    .rx_chr_valid(rx_chr_valid), .rx_chr_code(rx_chr_code), .rx_chr_k(rx_chr_k),
    .rx_policy(rx_policy), .rx_irq(rx_irq), .rx_rd(rx_rd), .rx_rd_vld(rx_rd_vld),
    .rx_rd_code(rx_rd_code), .rx_rd_k(rx_rd_k), .rx_avail(rx_avail), .rx_full(rx_full)
  );

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // transmit cycle model
  logic mq = 1'b0, mpend = 1'b0, mlvl = 1'b0, ev = 1'b0, ek = 1'b0;
  logic [7:0] ecode = '0;
  string etag = "R5";

  // receive model
  logic m_irq = 1'b0, m_lastfill = 1'b0;
  logic [7:0] exp_c [64];
  logic       exp_k [64];
  int eq_n = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  function automatic logic [15:0] step_lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic tx_step(input logic irq, input logic slot, input logic dv,
                         input logic [7:0] dc, input logic dk);
    logic edg;
    @(negedge clk);
    chk("R5", 32'(tx_chr_valid), 32'(ev));
    if (ev) begin
      chk(etag, 32'(tx_chr_code), 32'(ecode));
      chk(etag, 32'(tx_chr_k), 32'(ek));
    end
    tx_irq_lvl = irq; tx_slot = slot; tx_dat_valid = dv; tx_dat_code = dc; tx_dat_k = dk;
    #1;
    chk("R4", 32'(tx_dat_ready), 32'(slot & ~mpend & dv));
    edg = irq ^ mq;
    ev  = slot;
    if (slot) begin
      if (mpend) begin
        ecode = mlvl ? 8'h1C : 8'h7C; ek = 1'b1; etag = mlvl ? "R1" : "R2";
      end else if (dv) begin
        ecode = dc; ek = dk; etag = "R4";
      end else begin
        ecode = 8'hBC; ek = 1'b1; etag = "R5";
      end
    end
    if (edg) begin mpend = 1'b1; mlvl = irq; end
    else if (slot) mpend = 1'b0;
    mq = irq;
  endtask

  task automatic rx_send(input logic k, input logic [7:0] c, input logic [1:0] pol);
    logic is_cmd, is_fill, keep;
    @(negedge clk);
    rx_chr_valid = 1'b1; rx_chr_code = c; rx_chr_k = k; rx_policy = pol;
    is_cmd  = k && (c == 8'h1C || c == 8'h7C);
    is_fill = k && (c == 8'hBC);
    case (pol)
      2'd0:    keep = 1'b1;
      2'd1:    keep = !is_cmd && !(is_fill && m_lastfill);
      default: keep = !is_cmd && !is_fill;
    endcase
    if (keep) begin
      m_lastfill = is_fill;
      if (eq_n < DEPTH) begin exp_c[eq_n] = c; exp_k[eq_n] = k; eq_n++; end
    end
    if (k && c == 8'h1C) m_irq = 1'b1;
    if (k && c == 8'h7C) m_irq = 1'b0;
    @(negedge clk);
    rx_chr_valid = 1'b0;
    chk("R6", 32'(rx_irq), 32'(m_irq));
  endtask

  task automatic rx_drain(input string tag);
    bit anyd;
    @(negedge clk);
    @(negedge clk);
    anyd = 1'b0;
    for (int i = 0; i < eq_n; i++) if (!(exp_k[i] && exp_c[i] == 8'hBC)) anyd = 1'b1;
    chk("R10", 32'(rx_avail), 32'(anyd));
    for (int i = 0; i < eq_n; i++) begin
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      chk(tag, 32'(rx_rd_vld), 32'd1);
      chk(tag, 32'(rx_rd_code), 32'(exp_c[i]));
      chk(tag, 32'(rx_rd_k), 32'(exp_k[i]));
    end
    @(negedge clk);
    chk("R10", 32'(rx_avail), 32'd0);
    chk("R11", 32'(rx_full), 32'd0);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    chk(tag, 32'(rx_rd_vld), 32'd0);
    eq_n = 0;
  endtask

  initial begin
    logic cur;
    logic [7:0] c;
    logic k;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", 32'(tx_chr_valid), 32'd0);
    chk("R12", 32'(rx_irq), 32'd0);
    chk("R12", 32'(rx_avail), 32'd0);
    chk("R12", 32'(rx_full), 32'd0);
    chk("R12", 32'(rx_rd_vld), 32'd0);
    rst = 1'b0;

    // directed transmit sequences
    tx_step(0, 1, 0, 8'h00, 0);           // idle slot -> fill (R12: nothing pending)
    tx_step(1, 0, 0, 8'h00, 0);           // rising edge arms request
    tx_step(1, 1, 1, 8'h55, 0);           // request wins the slot
    tx_step(1, 1, 1, 8'h55, 0);           // data accepted now
    chk("R1", 32'(tx_chr_code), 32'h1C);
    tx_step(1, 0, 0, 8'h00, 0);
    chk("R4", 32'(tx_chr_code), 32'h55);
    tx_step(0, 0, 0, 8'h00, 0);           // three level changes, no slot
    tx_step(1, 0, 0, 8'h00, 0);
    tx_step(0, 0, 0, 8'h00, 0);
    tx_step(0, 1, 0, 8'h00, 0);
    tx_step(0, 1, 0, 8'h00, 0);
    chk("R3", 32'(tx_chr_code), 32'h7C);
    tx_step(0, 0, 0, 8'h00, 0);
    chk("R3", 32'(tx_chr_code), 32'hBC);

    // random sweep with edges colliding with slots
    cur = 1'b0;
    for (int n = 0; n < 600; n++) begin
      lfsr = step_lfsr(lfsr);
      if (lfsr[3:2] == 2'b00) cur = ~cur;
      tx_step(cur, lfsr[0] | lfsr[1], lfsr[5], lfsr[13:6], lfsr[14] & lfsr[15]);
    end
    tx_step(cur, 0, 0, 8'h00, 0);
    tx_step(cur, 0, 0, 8'h00, 0);

    // receive sweep over every policy
    for (int pol = 0; pol < 4; pol++) begin
      for (int t = 0; t < 12; t++) begin
        for (int i = 0; i < 10; i++) begin
          lfsr = step_lfsr(lfsr);
          case (lfsr[2:0])
            3'd0: begin k = 1'b0; c = 8'h35; end
            3'd1: begin k = 1'b0; c = 8'h1C; end
            3'd2: begin k = 1'b1; c = 8'h1C; end
            3'd3: begin k = 1'b1; c = 8'h7C; end
            3'd4: begin k = 1'b1; c = 8'hBC; end
            3'd5: begin k = 1'b1; c = 8'hBC; end
            3'd6: begin k = 1'b1; c = 8'hFC; end
            default: begin k = 1'b0; c = {4'hA, lfsr[7:4]}; end
          endcase
          rx_send(k, c, 2'(pol));
        end
        case (pol)
          0: rx_drain("R7");
          1: rx_drain("R8");
          default: rx_drain("R9");
        endcase
      end
    end

    // overflow
    for (int i = 0; i < DEPTH + 3; i++) rx_send(1'b0, 8'(8'h40 + i), 2'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R11", 32'(rx_full), 32'd1);
    rx_drain("R11");

    finish_run();
  end
endmodule